// File: doc/BRIEF.md
# Dual-Slot Transmit Frame Buffer

This block is the transmit side of a small Ethernet MAC. A host on a 32-bit register bus fills one of two frame slots with data, writes the byte count, and then writes a command into that slot's status word. The block then sends the slot's bytes out one at a time on a byte-wide valid/ready stream. Preamble, CRC and the PHY are handled downstream.

The status word of each slot also acts as its command port. Setting the busy bit on its own sends the frame. Setting busy together with the program bit copies the first six bytes of the slot into the station-address output, and nothing is sent. Hardware clears both bits when the operation ends, so software can poll for completion. Writing zero to the status word aborts the slot and leaves it idle. When two slots are waiting, they are served in the order they were started.

The second slot is present only when `DUAL_BUF` is 1. Each slot has the same layout and the two differ only in address bit 11. Inside a slot, frame data starts at byte offset 0x000, the length word is at 0x7F4 and the status word is at 0x7FC.

Top module: `txpp_frame_buf`

## Requirements
- R1: After reset, both status words read 0, `tx_valid` and `irq_tx_done` are low, and `station_addr` is 0.
- R2: Writing a status word with bit 0 (busy) set and bit 1 clear starts a send. Busy reads 1 until the last byte is accepted and then reads 0. Bytes leave in address order, and within a word the byte in bits 31:24 goes first. `tx_last` is high with the final byte.
- R3: The length word at slot offset 0x7F4 keeps its low 16 bits as the byte count, and its upper 16 bits read as 0. Counts that are not a multiple of four send only the stated number of bytes.
- R4: Writing 0x3 (busy and program) to a status word loads `station_addr` with the slot's first six bytes, the byte at offset 0 going into bits 47:40. Bits 0 and 1 then read 0, and no byte is sent.
- R5: Status bit 31 and bit 3 are stored and read back unchanged. Writing them without busy starts nothing.
- R6: When a send completes and status bit 3 of that slot is set, `irq_tx_done` is high for exactly one cycle. When bit 3 is clear, it stays low.
- R7: When both slots are busy, the slot started first is sent first. A slot started during another slot's send waits until that frame has ended.
- R8: Writing 0 to a busy slot's status word drops `tx_valid` in the next cycle and clears busy. No interrupt follows.
- R9: The second slot, at offset 0x800, holds its own data, length and status, and it sends independently of the first.
- R10: With `DUAL_BUF` = 0, writes at offset 0x800 and above have no effect, and reads there return 0.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold their values.
- R12: A send with a byte count of 0 clears busy without putting any byte on the stream. It still raises the interrupt when bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wen | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Byte address; bit ADDR_W-1 selects the slot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_valid | output | 1 | A frame byte is offered |
| tx_ready | input | 1 | Downstream accepts the byte this cycle |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| station_addr | output | 48 | Programmed station address |
| irq_tx_done | output | 1 | One-cycle pulse at the end of a send whose interrupt enable is set |

## Verification
Frames are sent with byte counts of 5, 8, 20 and 0. These show whether a partial last word is trimmed and whether big-endian byte order holds inside full words. The 20-byte frame runs under a pseudo-random ready pattern, which shows whether the stream holds its data when stalled and whether it skips or repeats bytes. One test keeps downstream stalled, starts the second slot and then the first, and checks that the queue is served in start order and not by slot index. Other tests program the address from each slot, abort a frame in mid-stall, and send in a single-slot build; these cover the program path, the abort path and the removed slot.

// File: rtl/txpp_pkg.sv
// Package: shared constants for the dual-slot transmit buffer.
// Assumes at most two frame slots and a 32-bit register bus.
package txpp_pkg;
    localparam int NSLOT    = 2;   // slot count the datapath is sized for
    localparam int BIT_BUSY = 0;   // status: start / in progress
    localparam int BIT_PROG = 1;   // status: load station address
    localparam int BIT_IE   = 3;   // status: completion interrupt enable
    localparam int BIT_FLAG = 31;  // status: software-only flag
endpackage

// File: rtl/txpp_buf.sv
// Module: one frame slot - data words, length word and status/command word.
// Assumes the slot's top three word addresses are length (DEPTH-3),
// unused (DEPTH-2) and status (DEPTH-1). Data words sit below the length word.
module txpp_buf
    import txpp_pkg::*;
#(
    parameter int WIDX_W = 9,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wen_i,
    input  logic [WIDX_W-1:0] widx_i,
    input  logic [31:0]       wdata_i,
    input  logic [WIDX_W-1:0] sidx_i,
    input  logic              done_i,
    output logic [31:0]       rdata_o,
    output logic [31:0]       sword_o,
    output logic [47:0]       head_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              busy_o,
    output logic              prog_o,
    output logic              ie_o,
    output logic              start_o
);
    localparam int DEPTH = 2 ** WIDX_W;
    localparam logic [WIDX_W-1:0] STAT_IDX = WIDX_W'(DEPTH - 1);
    localparam logic [WIDX_W-1:0] LEN_IDX  = WIDX_W'(DEPTH - 3);

    logic [31:0]      mem [0:DEPTH-1];
    logic [LEN_W-1:0] len_q;
    logic             busy_q, prog_q, ie_q, flag_q;
    logic             wr, wr_stat, wr_len, wr_data;

    // Purpose: decode the bus write into data, length and status targets.
    always_comb begin
        wr      = sel_i & wen_i;
        wr_stat = wr & (widx_i == STAT_IDX);
        wr_len  = wr & (widx_i == LEN_IDX);
        wr_data = wr & (widx_i < LEN_IDX);
        start_o = wr_stat & wdata_i[BIT_BUSY] & ~busy_q;
    end

    // Purpose: frame data storage, with no reset.
    always_ff @(posedge clk) begin
        if (wr_data) mem[widx_i] <= wdata_i;
    end

    // Purpose: length register.
    always_ff @(posedge clk) begin
        if (!rst_n)      len_q <= '0;
        else if (wr_len) len_q <= wdata_i[LEN_W-1:0];
    end

    // Purpose: status bits. A host command takes priority over completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            prog_q <= 1'b0;
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_stat) begin
                ie_q   <= wdata_i[BIT_IE];
                flag_q <= wdata_i[BIT_FLAG];
            end
            if (wr_stat && !wdata_i[BIT_BUSY]) begin
                busy_q <= 1'b0;
                prog_q <= 1'b0;
            end else if (wr_stat && !busy_q) begin
                busy_q <= 1'b1;
                prog_q <= wdata_i[BIT_PROG];
            end else if (done_i) begin
                busy_q <= 1'b0;
                prog_q <= 1'b0;
            end
        end
    end

    // Purpose: bus read mux and stream/program read ports.
    always_comb begin
        rdata_o = '0;
        if (widx_i == STAT_IDX) begin
            rdata_o[BIT_BUSY] = busy_q;
            rdata_o[BIT_PROG] = prog_q;
            rdata_o[BIT_IE]   = ie_q;
            rdata_o[BIT_FLAG] = flag_q;
        end else if (widx_i == LEN_IDX) begin
            rdata_o = 32'(len_q);
        end else if (widx_i < LEN_IDX) begin
            rdata_o = mem[widx_i];
        end
        sword_o = mem[sidx_i];
        head_o  = {mem[0], mem[1][31:16]};
        len_o   = len_q;
        busy_o  = busy_q;
        prog_o  = prog_q;
        ie_o    = ie_q;
    end

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !done_i && !wr_stat |=> busy_q);
    // R8
    cancel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat && !wdata_i[BIT_BUSY] |=> !busy_q && !prog_q);
    // R4
    prog_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_q |-> busy_q);
endmodule

// File: rtl/txpp_sched.sv
// Module: chooses which busy slot the engine serves next, in start order.
// Assumes two slots (an absent slot is tied to not-busy) and one start per cycle.
module txpp_sched (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] busy_i,
    input  logic [1:0] prog_i,
    input  logic [1:0] start_i,
    input  logic       idle_i,
    output logic       grant_vld_o,
    output logic       grant_idx_o,
    output logic       grant_prog_o
);
    logic first_q;

    // Purpose: remember which slot has been waiting longest.
    always_ff @(posedge clk) begin
        if (!rst_n)          first_q <= 1'b0;
        else if (start_i[0]) first_q <= busy_i[1];
        else if (start_i[1]) first_q <= ~busy_i[0];
    end

    // Purpose: offer the oldest busy slot while the engine is idle.
    always_comb begin
        grant_idx_o  = busy_i[first_q] ? first_q : ~first_q;
        grant_vld_o  = idle_i & (|busy_i);
        grant_prog_o = prog_i[grant_idx_o];
    end
endmodule

// File: rtl/txpp_engine.sv
// Module: runs one granted operation. It streams a frame byte by byte (big-endian
// in each word) or loads the station address. Assumes slot status is held outside.
module txpp_engine #(
    parameter int WIDX_W = 9,
    parameter int LEN_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  grant_vld_i,
    input  logic                  grant_idx_i,
    input  logic                  grant_prog_i,
    input  logic [1:0]            busy_i,
    input  logic [1:0]            ie_i,
    input  logic [1:0][LEN_W-1:0] len_i,
    input  logic [1:0][31:0]      word_i,
    input  logic [1:0][47:0]      head_i,
    input  logic                  tx_ready_i,
    output logic                  tx_valid_o,
    output logic [7:0]            tx_data_o,
    output logic                  tx_last_o,
    output logic                  idle_o,
    output logic [1:0]            done_o,
    output logic [WIDX_W-1:0]     sidx_o,
    output logic [47:0]           station_o,
    output logic                  irq_o
);
    logic             sending_q, cur_q, irq_q;
    logic [LEN_W-1:0] cnt_q, cur_len, g_len;
    logic [31:0]      cur_word;
    logic             active, last, accept, fin, take, g_zero, send_done, send_idx;

    // Purpose: stream-side status and completion strobes.
    always_comb begin
        cur_len  = len_i[cur_q];
        cur_word = word_i[cur_q];
        active   = sending_q & busy_i[cur_q];
        last     = (cnt_q == cur_len - LEN_W'(1));
        accept   = active & tx_ready_i;
        fin      = accept & last;
        take     = ~sending_q & grant_vld_i;
        g_len    = len_i[grant_idx_i];
        g_zero   = (g_len == '0);
        for (int b = 0; b < 2; b++) begin
            done_o[b] = (fin && (cur_q == 1'(b))) ||
                        (take && (grant_idx_i == 1'(b)) && (grant_prog_i || g_zero));
        end
        send_done = fin | (take & ~grant_prog_i & g_zero);
        send_idx  = fin ? cur_q : grant_idx_i;
        case (cnt_q[1:0])
            2'd0:    tx_data_o = cur_word[31:24];
            2'd1:    tx_data_o = cur_word[23:16];
            2'd2:    tx_data_o = cur_word[15:8];
            default: tx_data_o = cur_word[7:0];
        endcase
        tx_valid_o = active;
        tx_last_o  = active & last;
        idle_o     = ~sending_q;
        sidx_o     = cnt_q[WIDX_W+1:2];
        irq_o      = irq_q;
    end

    // Purpose: operation sequencing, byte counter and station-address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sending_q <= 1'b0;
            cur_q     <= 1'b0;
            cnt_q     <= '0;
            station_o <= '0;
        end else if (take) begin
            if (grant_prog_i) begin
                station_o <= head_i[grant_idx_i];
            end else if (!g_zero) begin
                sending_q <= 1'b1;
                cur_q     <= grant_idx_i;
                cnt_q     <= '0;
            end
        end else if (sending_q) begin
            if (!busy_i[cur_q])  sending_q <= 1'b0;
            else if (fin)        sending_q <= 1'b0;
            else if (accept)     cnt_q     <= cnt_q + LEN_W'(1);
        end
    end

    // Purpose: one-cycle completion interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= send_done & ie_i[send_idx];
    end

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && !tx_ready_i |=> $stable(cnt_q) && $stable(cur_q));
    // R7
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && !fin |=> sending_q && $stable(cur_q));
    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> cnt_q < cur_len);
endmodule

// File: rtl/txpp_frame_buf.sv
// Module: top of the dual-slot transmit buffer. It decodes the bus into slots,
// schedules them and streams frames. Assumes 32-bit word-aligned bus accesses
// and DUAL_BUF in {0,1}.
module txpp_frame_buf
    import txpp_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int LEN_W    = 16,
    parameter int DUAL_BUF = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic [47:0]       station_addr,
    output logic              irq_tx_done
);
    localparam int WIDX_W = ADDR_W - 3;
    localparam int NBUF   = (DUAL_BUF != 0) ? 2 : 1;

    logic                      hi;
    logic [WIDX_W-1:0]         widx, sidx;
    logic [NSLOT-1:0][31:0]    rdata_all, word_all;
    logic [NSLOT-1:0][47:0]    head_all;
    logic [NSLOT-1:0][LEN_W-1:0] len_all;
    logic [NSLOT-1:0]          busy_all, prog_all, ie_all, start_all, done_all;
    logic                      grant_vld, grant_idx, grant_prog, eng_idle;
    logic                      unused_lo;

    assign hi        = bus_addr[ADDR_W-1];
    assign widx      = bus_addr[ADDR_W-2:2];
    assign unused_lo = ^bus_addr[1:0];
    assign bus_rdata = rdata_all[hi];

    for (genvar b = 0; b < NSLOT; b++) begin : g_slot
        if (b < NBUF) begin : g_live
            txpp_buf #(.WIDX_W(WIDX_W), .LEN_W(LEN_W)) u_buf (
                .clk(clk), .rst_n(rst_n), .sel_i(hi == 1'(b)), .wen_i(bus_wen),
                .widx_i(widx), .wdata_i(bus_wdata), .sidx_i(sidx), .done_i(done_all[b]),
                .rdata_o(rdata_all[b]), .sword_o(word_all[b]), .head_o(head_all[b]),
                .len_o(len_all[b]), .busy_o(busy_all[b]), .prog_o(prog_all[b]),
                .ie_o(ie_all[b]), .start_o(start_all[b])
            );
        end else begin : g_absent
            logic unused_done;
            assign unused_done  = done_all[b];
            assign rdata_all[b] = '0;
            assign word_all[b]  = '0;
            assign head_all[b]  = '0;
            assign len_all[b]   = '0;
            assign busy_all[b]  = 1'b0;
            assign prog_all[b]  = 1'b0;
            assign ie_all[b]    = 1'b0;
            assign start_all[b] = 1'b0;
        end
    end

    txpp_sched u_sched (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_all), .prog_i(prog_all),
        .start_i(start_all), .idle_i(eng_idle), .grant_vld_o(grant_vld),
        .grant_idx_o(grant_idx), .grant_prog_o(grant_prog)
    );

    txpp_engine #(.WIDX_W(WIDX_W), .LEN_W(LEN_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .grant_vld_i(grant_vld), .grant_idx_i(grant_idx),
        .grant_prog_i(grant_prog), .busy_i(busy_all), .ie_i(ie_all), .len_i(len_all),
        .word_i(word_all), .head_i(head_all), .tx_ready_i(tx_ready),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last),
        .idle_o(eng_idle), .done_o(done_all), .sidx_o(sidx),
        .station_o(station_addr), .irq_o(irq_tx_done)
    );
endmodule

// File: tb/txpp_frame_buf_tb.sv
`timescale 1ns/100ps
module txpp_frame_buf_tb;
    localparam int STAT = 'h7FC;
    localparam int LENO = 'h7F4;
    localparam int PONG = 'h800;

    logic        clk = 0, rst_n = 0;
    logic        bus_wen = 0, wen_s = 0;
    logic [11:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata, rdata_s;
    logic        tx_valid, tx_ready = 1, tx_last, irq;
    logic [7:0]  tx_data;
    logic [47:0] station;
    logic        tx_valid_s, tx_last_s, irq_s;
    logic [7:0]  tx_data_s;
    logic [47:0] station_s;

    int  n_checks = 0, n_fail = 0, irq_seen = 0;
    logic [8:0] exp_q[$];
    logic [8:0] e;
    logic prev_v = 0, prev_r = 0, prev_l = 0, cancel_win = 0;
    logic [7:0] prev_d = 0;
    logic stall_mode = 0, ready_level = 1;
    logic [7:0] lfsr = 8'h5A;
    logic [31:0] rd;

    always #2 clk = ~clk;

    txpp_frame_buf u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .station_addr(station), .irq_tx_done(irq)
    );

    txpp_frame_buf #(.DUAL_BUF(0)) u_single (
        .clk(clk), .rst_n(rst_n), .bus_wen(wen_s), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_s), .tx_valid(tx_valid_s),
        .tx_ready(1'b1), .tx_data(tx_data_s), .tx_last(tx_last_s),
        .station_addr(station_s), .irq_tx_done(irq_s)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic wr(input int addr, input logic [31:0] data, input bit single = 0);
        @(posedge clk); #1;
        bus_addr = 12'(addr); bus_wdata = data;
        if (single) wen_s = 1; else bus_wen = 1;
        @(posedge clk); #1;
        bus_wen = 0; wen_s = 0;
    endtask

    task automatic rdreg(input int addr, output logic [31:0] val, input bit single = 0);
        @(posedge clk); #1;
        bus_addr = 12'(addr); bus_wen = 0; wen_s = 0;
        #0.5;
        val = single ? rdata_s : bus_rdata;
    endtask

    function automatic logic [7:0] fbyte(input logic [7:0] seed, input int i);
        return seed + 8'(i * 13);
    endfunction

    task automatic load_frame(input int base, input int n, input logic [7:0] seed);
        for (int w = 0; w < (n + 3) / 4; w++) begin
            logic [31:0] word = 0;
            for (int k = 0; k < 4; k++)
                if (w * 4 + k < n) word[31 - 8 * k -: 8] = fbyte(seed, w * 4 + k);
            wr(base + w * 4, word);
        end
        wr(base + LENO, 32'(n));
    endtask

    task automatic push_exp(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) exp_q.push_back({i == n - 1, fbyte(seed, i)});
    endtask

    task automatic wait_idle(input int base, input string tag);
        logic [31:0] v;
        int tries = 0;
        do begin
            rdreg(base + STAT, v);
            tries++;
        end while (v[0] && tries < 3000);
        chk(v[0] == 0, tag, v, 0);
        repeat (3) @(posedge clk);
    endtask

    // Ready driver: constant level or pseudo-random stalls
    initial forever begin
        @(posedge clk); #1;
        if (stall_mode) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tx_ready = lfsr[0];
        end else tx_ready = ready_level;
    end

    // Reference model: compare every handshake and stall against the expected byte queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) chk(0, "R2 unexpected byte", 64'(tx_data), 0);
                else begin
                    e = exp_q.pop_front();
                    chk({tx_last, tx_data} == e, "R2 byte and last order", 64'({tx_last, tx_data}), 64'(e));
                end
            end
            if (prev_v && !prev_r && !cancel_win)
                chk(tx_valid && tx_data == prev_d && tx_last == prev_l, "R11 stalled byte held",
                    64'({tx_valid, tx_last, tx_data}), 64'({1'b1, prev_l, prev_d}));
            if (irq) irq_seen++;
            if (tx_valid_s) chk(0, "R10 single build sent a byte", 1, 0);
            prev_v = tx_valid; prev_r = tx_ready; prev_d = tx_data; prev_l = tx_last;
        end
    end

    initial begin
        #(4 * 150000);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int irq0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rdreg(STAT, rd);        chk(rd == 0, "R1 slot0 status", rd, 0);
        rdreg(PONG + STAT, rd); chk(rd == 0, "R1 slot1 status", rd, 0);
        chk(!tx_valid && !irq && station == 0, "R1 outputs idle", 64'({tx_valid, irq, station}), 0);

        // R3 length word keeps 16 bits
        wr(LENO, 32'hABCD_0012); rdreg(LENO, rd);
        chk(rd == 32'h0000_0012, "R3 length readback", rd, 32'h12);

        // R5 flag and enable stored, no send started
        wr(STAT, 32'h8000_0008); rdreg(STAT, rd);
        chk(rd == 32'h8000_0008, "R5 flag/ie readback", rd, 32'h8000_0008);
        repeat (4) @(posedge clk);
        chk(!tx_valid, "R5 no send without busy", 64'(tx_valid), 0);

        // R2/R3/R6 five-byte frame in slot 0, interrupt enabled
        load_frame(0, 5, 8'h21); push_exp(5, 8'h21);
        irq0 = irq_seen;
        wr(STAT, 32'h9);
        rdreg(STAT, rd); chk(rd[0] == 1, "R2 busy while sending", rd, 1);
        wait_idle(0, "R2 busy clears after frame");
        chk(exp_q.size() == 0, "R3 partial word byte count", exp_q.size(), 0);
        chk(irq_seen == irq0 + 1, "R6 single irq pulse", irq_seen - irq0, 1);

        // R9/R6 eight-byte frame in slot 1, interrupt off
        load_frame(PONG, 8, 8'h90); push_exp(8, 8'h90);
        irq0 = irq_seen;
        wr(PONG + STAT, 32'h1);
        wait_idle(PONG, "R9 slot1 completes");
        chk(exp_q.size() == 0, "R9 slot1 bytes sent", exp_q.size(), 0);
        chk(irq_seen == irq0, "R6 no irq when disabled", irq_seen - irq0, 0);

        // R7 start order wins over slot index
        ready_level = 0;
        load_frame(0, 3, 8'h10);
        load_frame(PONG, 4, 8'h40);
        wr(PONG + STAT, 32'h1);
        wr(STAT, 32'h1);
        push_exp(4, 8'h40); push_exp(3, 8'h10);
        repeat (3) @(posedge clk);
        ready_level = 1;
        wait_idle(PONG, "R7 slot1 done");
        wait_idle(0, "R7 slot0 done");
        chk(exp_q.size() == 0, "R7 both frames drained", exp_q.size(), 0);

        // R11 random backpressure on a 20-byte frame
        stall_mode = 1;
        load_frame(0, 20, 8'h77); push_exp(20, 8'h77);
        wr(STAT, 32'h1);
        wait_idle(0, "R11 stalled frame completes");
        chk(exp_q.size() == 0, "R11 no byte lost", exp_q.size(), 0);
        stall_mode = 0;

        // R8 abort while stalled
        ready_level = 0;
        wr(LENO, 32'd40);
        irq0 = irq_seen;
        wr(STAT, 32'h9);
        repeat (3) @(posedge clk);
        chk(tx_valid, "R8 frame offered before abort", 64'(tx_valid), 1);
        cancel_win = 1;
        wr(STAT, 32'h0);
        chk(!tx_valid, "R8 valid drops on abort", 64'(tx_valid), 0);
        rdreg(STAT, rd); chk(rd[0] == 0, "R8 busy cleared", rd, 0);
        repeat (5) @(posedge clk);
        cancel_win = 0;
        ready_level = 1;
        repeat (5) @(posedge clk);
        chk(irq_seen == irq0, "R8 no irq after abort", irq_seen - irq0, 0);

        // R4 program station address from each slot
        wr(PONG + 0, 32'h0011_2233); wr(PONG + 4, 32'h4455_6677);
        wr(PONG + STAT, 32'h3);
        wait_idle(PONG, "R4 slot1 program completes");
        rdreg(PONG + STAT, rd); chk(rd[1:0] == 0, "R4 bits clear", rd, 0);
        chk(station == 48'h0011_2233_4455, "R4 station from slot1", station, 48'h0011_2233_4455);
        wr(0, 32'hA1B2_C3D4); wr(4, 32'hE5F6_0000);
        wr(STAT, 32'h3);
        wait_idle(0, "R4 slot0 program completes");
        chk(station == 48'hA1B2_C3D4_E5F6, "R4 station from slot0", station, 48'hA1B2_C3D4_E5F6);

        // R12 zero-length send
        irq0 = irq_seen;
        wr(LENO, 32'd0);
        wr(STAT, 32'h9);
        wait_idle(0, "R12 zero length clears busy");
        chk(irq_seen == irq0 + 1, "R12 irq on empty frame", irq_seen - irq0, 1);
        chk(exp_q.size() == 0, "R12 no bytes", exp_q.size(), 0);

        // R10 single-slot build ignores the upper half
        wr(STAT, 32'h8, 1);
        rdreg(STAT, rd, 1); chk(rd == 32'h8, "R10 slot0 present", rd, 8);
        wr(PONG + LENO, 32'd4, 1);
        wr(PONG + STAT, 32'h8000_0009, 1);
        rdreg(PONG + STAT, rd, 1); chk(rd == 0, "R10 upper status reads 0", rd, 0);
        rdreg(PONG + LENO, rd, 1); chk(rd == 0, "R10 upper length reads 0", rd, 0);
        repeat (6) @(posedge clk);
        chk(!tx_valid_s && !irq_s, "R10 nothing started", 64'({tx_valid_s, irq_s}), 0);

        finish_run();
    end
endmodule